// File: doc/BRIEF.md
# Length-Decoded Serial Register Port

This block is the receive side of a three-wire serial port (active-low enable, data clock, data input) that loads one of three configuration registers. No address or steering bits travel in the stream. The register that a transfer lands in is chosen only by the number of data-clock pulses seen while the enable was low. The choice is made when the enable returns high. Every bit of a transfer is therefore payload, and the three registers may be written in any order.

A 16-bit divider write also emits a one-cycle load strobe, so that downstream counters can be jam-loaded together. Two length patterns act as a device reset: a 4-pulse transfer followed at once by a 5-pulse transfer, and any transfer of more than 32 pulses. A three-state serial output passes the shifted-out bits onward so that devices can be chained or read back for a loop-back test.

The serial clock, enable and data are brought into the system clock domain through synchronizer chains, and all serial activity is handled on the detected edges. The system clock must run several times faster than the serial clock.

Top module: `lds_port`

## Requirements
- R1: Data is shifted in most significant bit first, one bit per rising edge of `ser_clk` while `ser_en_n` is low. The last bit of a transfer becomes bit 0 of the target register.
- R2: A transfer of exactly 8 pulses loads its last 8 bits into `cfg_q` and leaves `ndiv_q` and `rdiv_q` unchanged.
- R3: A transfer of exactly 16 pulses loads its last 16 bits into `ndiv_q` and raises `ndiv_load` for exactly one system clock cycle. No other transfer length raises `ndiv_load`.
- R4: A transfer of 15 or of 24 pulses loads its last 15 bits into `rdiv_q`. In the 24-pulse form the first 9 bits are ignored.
- R5: Every other length from 1 to 32 writes no register, and a 5-pulse transfer not directly preceded by a 4-pulse transfer is one of these. The registers do not change while a transfer is shifting. They change only after the enable's rising edge.
- R6: A 4-pulse transfer followed directly by a 5-pulse transfer pulses `soft_rst` for one cycle and returns the registers to their reset values.
- R7: A transfer of more than 32 pulses (33 included) has the same effect as R6. The internal pulse counter saturates and does not wrap.
- R8: While `ser_en_n` is high, `ser_dout_oe` is low and `ser_clk` pulses are ignored: they add nothing to the length of the next transfer.
- R9: While `ser_en_n` is low, `ser_dout_oe` is high. After k rising and k falling `ser_clk` edges with k of at least 16, `ser_dout` equals stream bit k-16, counted from 0 at the first bit sent.
- R10: After `rst_n` is released, `cfg_q` is 8'h10, `ndiv_q` and `rdiv_q` are 0, and `ndiv_load`, `soft_rst` and `ser_dout_oe` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial data clock |
| ser_en_n | input | 1 | Active-low transfer enable |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_dout | output | 1 | Serial pass-through data out |
| ser_dout_oe | output | 1 | Output enable for `ser_dout` |
| cfg_q | output | 8 | Configuration register |
| ndiv_q | output | 16 | Feedback divider register |
| rdiv_q | output | 15 | Reference divider register |
| ndiv_load | output | 1 | One-cycle strobe on a divider write, used to jam-load the counters |
| soft_rst | output | 1 | One-cycle soft reset pulse |

## Verification
Several properties are checked on every cycle by assertions. The output enable stays off while the enable is high. The pulse counter stays at or below its saturation value and clears while the port is idle. The registers hold steady except in the cycle after a commit. The load strobe lasts one cycle and follows a commit. A soft reset always leaves the reset values in place. Only the bench's scenarios can show that each transfer length lands in the right register with the right bits. The same holds for the 4-then-5 pattern needing two transfers in sequence, for the 32/33 boundary, for pulses sent while idle being dropped, and for the pass-through output carrying the stream delayed by sixteen bits.

// File: rtl/lds_pkg.sv
package lds_pkg;

   typedef enum logic [2:0] {
      TGT_NONE  = 3'd0,
      TGT_CFG   = 3'd1,
      TGT_NDIV  = 3'd2,
      TGT_RDIV  = 3'd3,
      TGT_RESET = 3'd4
   } lds_tgt_e;

   function automatic int lds_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/lds_sync.sv
module lds_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("lds_sync: STAGES must be at least 2");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d_in[b]};
         end
         assign d_out[b] = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lds_shifter.sv
module lds_shifter #(
   parameter int SR_W    = 16,
   parameter int CNT_SAT = 33,
   localparam int CNT_W  = $clog2(CNT_SAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_s,
   input  logic             en_n_s,
   input  logic             din_s,
   output logic [SR_W-1:0]  sr_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             commit_p,
   output logic             dout_q
);

   logic sclk_d;
   logic en_d;
   logic s_rise;
   logic s_fall;

   assign s_rise   = sclk_s & ~sclk_d;
   assign s_fall   = ~sclk_s & sclk_d;
   assign commit_p = en_n_s & ~en_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         en_d   <= 1'b1;
         sr_q   <= '0;
         cnt_q  <= '0;
         dout_q <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         en_d   <= en_n_s;
         if (en_n_s) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            dout_q <= 1'b0;
         end else begin
            if (s_rise) begin
               sr_q <= {sr_q[SR_W-2:0], din_s};
               if (cnt_q != CNT_W'(CNT_SAT)) cnt_q <= cnt_q + 1'b1;
            end
            if (s_fall) dout_q <= sr_q[SR_W-1];
         end
      end
   end

   p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(CNT_SAT));

   p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      en_n_s |=> (cnt_q == '0));

   p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n_s && s_rise) |=> (sr_q[0] == $past(din_s)));

endmodule

// File: rtl/lds_commit.sv
module lds_commit
   import lds_pkg::*;
#(
   parameter int CFG_W          = 8,
   parameter int NDIV_W         = 16,
   parameter int RDIV_W         = 15,
   parameter int RDIV_ALT_LEN   = 24,
   parameter int RST_PRE_LEN    = 4,
   parameter int RST_POST_LEN   = 5,
   parameter int LONG_RST_ABOVE = 32,
   parameter int SR_W           = 16,
   parameter int CNT_W          = 6,
   parameter logic [CFG_W-1:0]  CFG_RST  = '0,
   parameter logic [NDIV_W-1:0] NDIV_RST = '0,
   parameter logic [RDIV_W-1:0] RDIV_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_p,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [SR_W-1:0]   sr,
   output logic [CFG_W-1:0]  cfg_q,
   output logic [NDIV_W-1:0] ndiv_q,
   output logic [RDIV_W-1:0] rdiv_q,
   output logic              ndiv_load,
   output logic              soft_rst
);

   lds_tgt_e tgt;
   logic     r_hit;
   logic     saw_pre;

   generate
      if (RDIV_ALT_LEN > 0) begin : g_r_two
         assign r_hit = (cnt == CNT_W'(RDIV_W)) || (cnt == CNT_W'(RDIV_ALT_LEN));
      end else begin : g_r_one
         assign r_hit = (cnt == CNT_W'(RDIV_W));
      end
   endgenerate

   // Priority: long reset, reset pattern, then the three lengths.
   always_comb begin
      tgt = TGT_NONE;
      if (cnt > CNT_W'(LONG_RST_ABOVE))                          tgt = TGT_RESET;
      else if (saw_pre && (cnt == CNT_W'(RST_POST_LEN)))         tgt = TGT_RESET;
      else if (cnt == CNT_W'(CFG_W))                             tgt = TGT_CFG;
      else if (cnt == CNT_W'(NDIV_W))                            tgt = TGT_NDIV;
      else if (r_hit)                                            tgt = TGT_RDIV;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= CFG_RST;
         ndiv_q    <= NDIV_RST;
         rdiv_q    <= RDIV_RST;
         ndiv_load <= 1'b0;
         soft_rst  <= 1'b0;
         saw_pre   <= 1'b0;
      end else begin
         ndiv_load <= 1'b0;
         soft_rst  <= 1'b0;
         if (commit_p) begin
            saw_pre <= (cnt == CNT_W'(RST_PRE_LEN));
            unique case (tgt)
               TGT_CFG:  cfg_q <= sr[CFG_W-1:0];
               TGT_NDIV: begin
                  ndiv_q    <= sr[NDIV_W-1:0];
                  ndiv_load <= 1'b1;
               end
               TGT_RDIV: rdiv_q <= sr[RDIV_W-1:0];
               TGT_RESET: begin
                  cfg_q    <= CFG_RST;
                  ndiv_q   <= NDIV_RST;
                  rdiv_q   <= RDIV_RST;
                  soft_rst <= 1'b1;
                  saw_pre  <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_p |=> ($stable(cfg_q) && $stable(ndiv_q) && $stable(rdiv_q)));

   p_load_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ndiv_load |=> !ndiv_load);

   p_load_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ndiv_load |-> $past(commit_p));

   p_rst_values_r6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> (cfg_q == CFG_RST && ndiv_q == NDIV_RST && rdiv_q == RDIV_RST && !ndiv_load));

endmodule

// File: rtl/lds_port.sv
module lds_port #(
   parameter int CFG_W          = 8,
   parameter int NDIV_W         = 16,
   parameter int RDIV_W         = 15,
   parameter int RDIV_ALT_LEN   = 24,
   parameter int RST_PRE_LEN    = 4,
   parameter int RST_POST_LEN   = 5,
   parameter int LONG_RST_ABOVE = 32,
   parameter int SYNC_STAGES    = 2,
   parameter logic [CFG_W-1:0]  CFG_RST  = 8'h10,
   parameter logic [NDIV_W-1:0] NDIV_RST = '0,
   parameter logic [RDIV_W-1:0] RDIV_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_en_n,
   input  logic              ser_din,
   output logic              ser_dout,
   output logic              ser_dout_oe,
   output logic [CFG_W-1:0]  cfg_q,
   output logic [NDIV_W-1:0] ndiv_q,
   output logic [RDIV_W-1:0] rdiv_q,
   output logic              ndiv_load,
   output logic              soft_rst
);

   localparam int SR_W    = lds_pkg::lds_max3(CFG_W, NDIV_W, RDIV_W);
   localparam int CNT_SAT = LONG_RST_ABOVE + 1;
   localparam int CNT_W   = $clog2(CNT_SAT + 1);

   generate
      if (CFG_W == NDIV_W || CFG_W == RDIV_W || NDIV_W == RDIV_W) begin : g_chk_len
         $error("lds_port: register lengths must differ");
      end
      if (RDIV_ALT_LEN != 0 && (RDIV_ALT_LEN < RDIV_W || RDIV_ALT_LEN > LONG_RST_ABOVE)) begin : g_chk_alt
         $error("lds_port: RDIV_ALT_LEN out of range");
      end
      if (SR_W > LONG_RST_ABOVE || RST_POST_LEN > LONG_RST_ABOVE) begin : g_chk_long
         $error("lds_port: lengths must stay below the long-reset threshold");
      end
   endgenerate

   logic [2:0]       sync_q;
   logic             sclk_s;
   logic             en_n_s;
   logic             din_s;
   logic [SR_W-1:0]  sr;
   logic [CNT_W-1:0] cnt;
   logic             commit_p;
   logic             dout_q;

   lds_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({ser_en_n, ser_clk, ser_din}),
      .d_out (sync_q)
   );
   assign {en_n_s, sclk_s, din_s} = sync_q;

   lds_shifter #(.SR_W(SR_W), .CNT_SAT(CNT_SAT)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (sclk_s),
      .en_n_s   (en_n_s),
      .din_s    (din_s),
      .sr_q     (sr),
      .cnt_q    (cnt),
      .commit_p (commit_p),
      .dout_q   (dout_q)
   );

   lds_commit #(
      .CFG_W(CFG_W), .NDIV_W(NDIV_W), .RDIV_W(RDIV_W), .RDIV_ALT_LEN(RDIV_ALT_LEN),
      .RST_PRE_LEN(RST_PRE_LEN), .RST_POST_LEN(RST_POST_LEN),
      .LONG_RST_ABOVE(LONG_RST_ABOVE), .SR_W(SR_W), .CNT_W(CNT_W),
      .CFG_RST(CFG_RST), .NDIV_RST(NDIV_RST), .RDIV_RST(RDIV_RST)
   ) u_commit (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit_p  (commit_p),
      .cnt       (cnt),
      .sr        (sr),
      .cfg_q     (cfg_q),
      .ndiv_q    (ndiv_q),
      .rdiv_q    (rdiv_q),
      .ndiv_load (ndiv_load),
      .soft_rst  (soft_rst)
   );

   assign ser_dout    = dout_q;
   assign ser_dout_oe = ~ser_en_n & ~en_n_s;

   p_oe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ser_en_n |-> !ser_dout_oe);

   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ndiv_load, soft_rst}));

endmodule

// File: tb/lds_port_test.sv
module lds_port_test;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_en_n = 1'b1;
   logic        ser_din = 1'b0;
   logic        ser_dout;
   logic        ser_dout_oe;
   logic [7:0]  cfg_q;
   logic [15:0] ndiv_q;
   logic [14:0] rdiv_q;
   logic        ndiv_load;
   logic        soft_rst;

   int checks = 0;
   int errors = 0;
   int nl_cyc = 0;
   int sr_cyc = 0;
   bit done   = 0;

   logic [7:0]  e_cfg  = 8'h10;
   logic [15:0] e_ndiv = '0;
   logic [14:0] e_rdiv = '0;
   bit          e_pre  = 0;
   int          e_nl   = 0;
   int          e_sr   = 0;

   lds_port uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
      .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
      .cfg_q(cfg_q), .ndiv_q(ndiv_q), .rdiv_q(rdiv_q),
      .ndiv_load(ndiv_load), .soft_rst(soft_rst)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (ndiv_load) nl_cyc++;
      if (soft_rst)  sr_cyc++;
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic string tag_of(input int n);
      if (n > 32) return "R7";
      if (n == 8) return "R2";
      if (n == 16) return "R3";
      if (n == 15 || n == 24) return "R4";
      if (n == 5 && e_pre) return "R6";
      return "R5";
   endfunction

   // Expected effect of a committed transfer of n pulses.
   task automatic model(input int n, input logic [63:0] b);
      e_nl = 0;
      e_sr = 0;
      if (n > 32 || (n == 5 && e_pre)) begin
         e_cfg = 8'h10; e_ndiv = '0; e_rdiv = '0; e_sr = 1; e_pre = 0;
      end else begin
         if (n == 8)  e_cfg = b[7:0];
         if (n == 16) begin e_ndiv = b[15:0]; e_nl = 1; end
         if (n == 15 || n == 24) e_rdiv = b[14:0];
         e_pre = (n == 4);
      end
   endtask

   task automatic check_regs(input string req);
      chk(req, "cfg_q", 32'(cfg_q), 32'(e_cfg));
      chk(req, "ndiv_q", 32'(ndiv_q), 32'(e_ndiv));
      chk(req, "rdiv_q", 32'(rdiv_q), 32'(e_rdiv));
      chk(req == "R6" || req == "R7" ? req : "R3", "ndiv_load cycles", 32'(nl_cyc), 32'(e_nl));
      chk(req == "R3" ? "R6" : req, "soft_rst cycles", 32'(sr_cyc), 32'(e_sr));
   endtask

   // n pulses, bits MSB first (b[n-1] first); checks pass-through output.
   task automatic xfer(input int n, input logic [63:0] b, input bit chk_dout);
      logic [7:0]  c0;
      logic [15:0] n0;
      logic [14:0] r0;
      bit          dok;
      string       t;
      t = tag_of(n);
      dok = 1;
      nl_cyc = 0;
      sr_cyc = 0;
      ser_en_n = 1'b0;
      waitn(HALF);
      if (chk_dout) chk("R9", "ser_dout_oe while enabled", 32'(ser_dout_oe), 32'd1);
      c0 = cfg_q; n0 = ndiv_q; r0 = rdiv_q;
      for (int i = 0; i < n; i++) begin
         ser_din = b[n-1-i];
         waitn(HALF);
         if (i >= 16 && ser_dout !== b[n-1-(i-16)]) dok = 0;
         ser_clk = 1'b1;
         waitn(HALF);
         ser_clk = 1'b0;
      end
      waitn(HALF);
      if (n >= 16 && ser_dout !== b[15]) dok = 0;
      if (chk_dout) chk("R9", "ser_dout stream", 32'(dok), 32'd1);
      chk("R5", "regs steady while shifting",
          32'((cfg_q == c0) && (ndiv_q == n0) && (rdiv_q == r0)), 32'd1);
      ser_en_n = 1'b1;
      waitn(8);
      model(n, b);
      check_regs(t);
   endtask

   task automatic idle_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         waitn(HALF);
         ser_clk = 1'b1;
         if (i == 0) begin
            waitn(2);
            chk("R8", "ser_dout_oe while idle", 32'(ser_dout_oe), 32'd0);
            waitn(HALF - 2);
         end else waitn(HALF);
         ser_clk = 1'b0;
      end
      waitn(HALF);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] rb;
      int          n;
      void'($urandom(32'd5147));
      waitn(3);
      rst_n = 1'b1;
      waitn(4);
      // R10 reset state
      chk("R10", "cfg_q", 32'(cfg_q), 32'h10);
      chk("R10", "ndiv_q", 32'(ndiv_q), 32'h0);
      chk("R10", "rdiv_q", 32'(rdiv_q), 32'h0);
      chk("R10", "strobes", 32'({ndiv_load, soft_rst}), 32'h0);
      chk("R10", "ser_dout_oe", 32'(ser_dout_oe), 32'h0);

      xfer(8,  64'hA5, 1'b0);                   // R1 R2
      xfer(16, 64'h1234, 1'b1);                 // R3 R9
      xfer(15, 64'h5ABC, 1'b0);                 // R4
      xfer(24, 64'hFFF123, 1'b1);               // R4 R9
      xfer(12, 64'hFFF, 1'b0);                  // R5
      xfer(5,  64'h1F, 1'b0);                   // R5: 5 without 4
      xfer(4,  64'h0, 1'b0);                    // R6 first part
      xfer(5,  64'h0, 1'b0);                    // R6
      xfer(8,  64'h3C, 1'b0);
      xfer(32, 64'hFFFF_FFFF, 1'b1);            // R5 boundary
      xfer(33, 64'h1_2345_6789, 1'b1);          // R7 boundary
      xfer(16, 64'hBEEF, 1'b0);
      xfer(40, 64'hFF_FFFF_FFFF, 1'b0);         // R7
      idle_pulses(8);                           // R8
      xfer(8,  64'h77, 1'b0);                   // R8: would be 16 if counted
      chk("R8", "ndiv_q after idle pulses", 32'(ndiv_q), 32'h0);

      for (int k = 0; k < 70; k++) begin
         rb = {$urandom, $urandom};
         case ($urandom_range(0, 6))
            0: n = 8;
            1: n = 16;
            2: n = 15;
            3: n = 24;
            4: begin xfer(4, rb, 1'b0); n = 5; end
            default: n = $urandom_range(1, 40);
         endcase
         xfer(n, rb, (k % 5) == 0);
         if ((k % 10) == 0) idle_pulses($urandom_range(1, 6));
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule